// File: doc/BRIEF.md
# Locked Configuration Word Store

This block holds the configuration image of a small programmable logic device. The image has four parts. The first is the product-term array contents. The second is the architecture control word pair: a polarity bit and an I/O-select bit for each of eight output cells, plus two global mode bits. The third is a 64-bit user signature. The fourth is a one-way read-protection bit. A host reaches every stored word through one addressed, word-wide command interface. The commands are write, read, bulk erase and lock.

After the protection bit is set, reads of the array and architecture words come back as zeros and raise a refusal flag. The signature and a running 16-bit checksum stay visible. Only a bulk erase clears the protection bit. The erase clears one word per cycle and holds a busy flag while it runs. The architecture bits drive the device's cell configuration outputs at all times, whatever the state of the protection bit.

Top module: `cfg_store`

## Requirements
- R1: During and right after synchronous reset, every stored word is zero. `busy`, `locked`, `rvalid` and `denied` are low, and `rdata`, `checksum` and the cell configuration outputs are zero.
- R2: The command code sits on `cmd`: 0 is idle, 1 is write, 2 is read, 3 is erase, 4 is lock, and 5 to 7 act as idle. A read of a mapped, readable address raises `rvalid` for exactly one cycle, starting at the clock edge that takes the command. In that cycle `rdata` holds the last word written to that address.
- R3: The address map, with N = ARRAY_WORDS, is as follows. Addresses 0..N-1 are array words. Address N holds the polarity bits for cells 0..7 in bits 7:0 and the I/O-select bits for cells 0..7 in bits 15:8. Address N+1 keeps only bits 1:0, the two global mode bits. Its upper bits always read back as 0.
- R4: While `locked` is high, a read of an array word or an architecture word returns `rdata` = 0. It also raises `denied` together with `rvalid` for one cycle. The lock command sets `locked`.
- R5: The signature words at addresses N+2..N+5 read back normally while locked, and `denied` stays low.
- R6: `checksum` always equals the modulo-2^16 sum of every stored word, signature words included, and it is visible while locked.
- R7: An erase clears `locked` at the edge that takes it. It then holds `busy` high for exactly N+6 cycles and clears every stored word. When it ends, `checksum` is 0.
- R8: Any command that arrives while `busy` is high is ignored. A write changes nothing, and a read gives no `rvalid`.
- R9: A write while `locked` is high is ignored. The stored word and `checksum` keep their values.
- R10: A write to an address at or above N+6 is ignored. A read there returns `rvalid` with `rdata` = 0 and `denied` low.
- R11: `cell_pol`, `cell_io` and `mode_bits` always show the stored architecture bits, and the lock does not change them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd | input | 3 | Command code (R2) |
| addr | input | AW = clog2(N+7) | Word address |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid with `rvalid` |
| rvalid | output | 1 | One-cycle read response strobe |
| denied | output | 1 | Read refused because of the lock |
| busy | output | 1 | Erase in progress |
| locked | output | 1 | Read protection active |
| checksum | output | 16 | Running sum of all stored words |
| cell_pol | output | 8 | Polarity bit per output cell |
| cell_io | output | 8 | I/O-select bit per output cell |
| mode_bits | output | 2 | Global mode bits |

## Verification
The hardest situation to reach is a command that lands inside the erase sweep. It has to arrive after the sweep has already cleared its target word, so that a write which was not ignored would survive the erase. The bench therefore counts busy cycles after the erase edge. On the fourth of them it issues a write to address 0, which the sweep cleared at its first step. On the next cycle it issues a read. It then checks that `rvalid` stayed low, that the final checksum is zero and that address 0 reads back as zero. Lock behaviour is reached by first filling all three regions with known values, so that a zero read under lock can be told apart from an empty word.

// File: rtl/cfg_store_pkg.sv
package cfg_store_pkg;

    localparam int WORD_W     = 16;
    localparam int CELLS      = 8;
    localparam int ARCH_WORDS = 2;
    localparam int SIG_BITS   = 64;
    localparam int SIG_WORDS  = SIG_BITS / WORD_W;
    localparam int MODE_W     = 2;

    typedef logic [WORD_W-1:0] word_t;

    typedef enum logic [2:0] {
        CMD_IDLE  = 3'd0,
        CMD_WRITE = 3'd1,
        CMD_READ  = 3'd2,
        CMD_ERASE = 3'd3,
        CMD_LOCK  = 3'd4
    } cmd_e;

    typedef enum logic [1:0] {
        RGN_ARRAY,
        RGN_ARCH,
        RGN_SIG,
        RGN_NONE
    } region_e;

    typedef struct packed {
        logic [MODE_W-1:0] mode;
        logic [CELLS-1:0]  io;
        logic [CELLS-1:0]  pol;
    } arch_t;

    // Regions whose readback the protection bit hides.
    function automatic logic hidden_when_locked(input region_e r);
        return (r == RGN_ARRAY) || (r == RGN_ARCH);
    endfunction

    // Bits kept when a word is stored.
    function automatic word_t keep_mask(input region_e r, input logic upper_arch);
        if (r == RGN_ARCH && upper_arch)
            return word_t'((1 << MODE_W) - 1);
        return '1;
    endfunction

endpackage

// File: rtl/cfg_addr_decode.sv
module cfg_addr_decode
    import cfg_store_pkg::*;
#(
    parameter int ARRAY_WORDS = 8,
    parameter int AW          = 4,
    parameter int IW          = 4
) (
    input  logic [AW-1:0] addr,
    output region_e       region,
    output logic [IW-1:0] idx,
    output word_t         mask
);
    localparam int ARCH_BASE = ARRAY_WORDS;
    localparam int SIG_BASE  = ARRAY_WORDS + ARCH_WORDS;
    localparam int TOTAL     = SIG_BASE + SIG_WORDS;

    int a;

    always_comb begin
        a   = int'(addr);
        idx = addr[IW-1:0];
        if (a < ARCH_BASE)
            region = RGN_ARRAY;
        else if (a < SIG_BASE)
            region = RGN_ARCH;
        else if (a < TOTAL)
            region = RGN_SIG;
        else
            region = RGN_NONE;
        mask = keep_mask(region, a == ARCH_BASE + 1);
    end

endmodule

// File: rtl/cfg_word_store.sv
module cfg_word_store
    import cfg_store_pkg::*;
#(
    parameter int TOTAL = 14,
    parameter int IW    = 4
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          wr_en,
    input  logic [IW-1:0]                 wr_idx,
    input  word_t                         wr_val,
    input  logic                          erase_go,
    output logic [TOTAL-1:0][WORD_W-1:0]  words,
    output logic                          busy,
    output word_t                         checksum
);
    logic [IW-1:0] sweep;
    logic          sweep_last;

    assign sweep_last = (int'(sweep) == TOTAL - 1);

    // Erase walks one word per cycle; the sum is kept by subtracting old and adding new.
    always_ff @(posedge clk) begin
        if (rst) begin
            words    <= '0;
            busy     <= 1'b0;
            sweep    <= '0;
            checksum <= '0;
        end else if (busy) begin
            words[sweep] <= '0;
            checksum     <= checksum - words[sweep];
            if (sweep_last) begin
                busy  <= 1'b0;
                sweep <= '0;
            end else begin
                sweep <= sweep + 1'b1;
            end
        end else if (erase_go) begin
            busy  <= 1'b1;
            sweep <= '0;
        end else if (wr_en) begin
            words[wr_idx] <= wr_val;
            checksum      <= checksum - words[wr_idx] + wr_val;
        end
    end

    // R7: an accepted erase raises busy on the next cycle
    a_r7_erase_starts: assert property (@(posedge clk) disable iff (rst)
        (!busy && erase_go) |=> busy);

    // R7: the last sweep step ends busy with an empty sum
    a_r7_sweep_ends_clean: assert property (@(posedge clk) disable iff (rst)
        (busy && sweep_last) |=> (!busy && checksum == '0));

endmodule

// File: rtl/cfg_read_gate.sv
module cfg_read_gate
    import cfg_store_pkg::*;
(
    input  logic    clk,
    input  logic    rst,
    input  logic    rd_go,
    input  region_e region,
    input  word_t   rd_word,
    input  logic    lock_go,
    input  logic    erase_go,
    output word_t   rdata,
    output logic    rvalid,
    output logic    denied,
    output logic    locked
);
    logic refuse;

    assign refuse = locked && hidden_when_locked(region);

    always_ff @(posedge clk) begin
        if (rst) begin
            locked <= 1'b0;
        end else if (erase_go) begin
            locked <= 1'b0;
        end else if (lock_go) begin
            locked <= 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata  <= '0;
            rvalid <= 1'b0;
            denied <= 1'b0;
        end else begin
            rvalid <= rd_go;
            denied <= rd_go && refuse;
            if (rd_go && !refuse && region != RGN_NONE)
                rdata <= rd_word;
            else
                rdata <= '0;
        end
    end

    // R4: a refused read never exposes data
    a_r4_refusal_is_zero: assert property (@(posedge clk) disable iff (rst)
        denied |-> (rvalid && rdata == '0));

    // R5: signature reads are never refused
    a_r5_signature_open: assert property (@(posedge clk) disable iff (rst)
        (rd_go && region == RGN_SIG) |=> !denied);

    // R2: an accepted read answers on the next cycle
    a_r2_read_answers: assert property (@(posedge clk) disable iff (rst)
        rd_go |=> rvalid);

endmodule

// File: rtl/cfg_store.sv
module cfg_store
    import cfg_store_pkg::*;
#(
    parameter  int ARRAY_WORDS = 8,
    localparam int TOTAL       = ARRAY_WORDS + ARCH_WORDS + SIG_WORDS,
    localparam int AW          = $clog2(TOTAL + 1),
    localparam int IW          = $clog2(TOTAL)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [2:0]        cmd,
    input  logic [AW-1:0]     addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata,
    output logic              rvalid,
    output logic              denied,
    output logic              busy,
    output logic              locked,
    output logic [WORD_W-1:0] checksum,
    output logic [CELLS-1:0]  cell_pol,
    output logic [CELLS-1:0]  cell_io,
    output logic [MODE_W-1:0] mode_bits
);
    region_e                        region;
    logic [IW-1:0]                  idx;
    word_t                          mask;
    logic [TOTAL-1:0][WORD_W-1:0]   words;
    word_t                          rd_word;
    arch_t                          arch;
    logic                           idle;
    logic                           wr_en, rd_go, erase_go, lock_go;

    cfg_addr_decode #(
        .ARRAY_WORDS (ARRAY_WORDS),
        .AW          (AW),
        .IW          (IW)
    ) u_decode (
        .addr   (addr),
        .region (region),
        .idx    (idx),
        .mask   (mask)
    );

    assign idle     = !busy;
    assign wr_en    = idle && cmd == CMD_WRITE && !locked && region != RGN_NONE;
    assign rd_go    = idle && cmd == CMD_READ;
    assign erase_go = idle && cmd == CMD_ERASE;
    assign lock_go  = idle && cmd == CMD_LOCK;

    cfg_word_store #(
        .TOTAL (TOTAL),
        .IW    (IW)
    ) u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_en),
        .wr_idx   (idx),
        .wr_val   (wdata & mask),
        .erase_go (erase_go),
        .words    (words),
        .busy     (busy),
        .checksum (checksum)
    );

    assign rd_word = (region == RGN_NONE) ? '0 : words[idx];

    cfg_read_gate u_gate (
        .clk      (clk),
        .rst      (rst),
        .rd_go    (rd_go),
        .region   (region),
        .rd_word  (rd_word),
        .lock_go  (lock_go),
        .erase_go (erase_go),
        .rdata    (rdata),
        .rvalid   (rvalid),
        .denied   (denied),
        .locked   (locked)
    );

    assign arch      = arch_t'({words[ARRAY_WORDS+1][MODE_W-1:0], words[ARRAY_WORDS]});
    assign cell_pol  = arch.pol;
    assign cell_io   = arch.io;
    assign mode_bits = arch.mode;

    // R8: reads issued during an erase get no answer
    a_r8_busy_read_dropped: assert property (@(posedge clk) disable iff (rst)
        (busy && cmd == CMD_READ) |=> !rvalid);

    // R9: a write under lock leaves the sum untouched
    a_r9_locked_write_inert: assert property (@(posedge clk) disable iff (rst)
        (locked && !busy && cmd == CMD_WRITE) |=> $stable(checksum));

    // R7: an erase always runs unlocked
    a_r7_erase_unlocks: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> !locked);

endmodule

// File: tb/test_cfg_store.sv
module test_cfg_store;
    localparam int N     = 8;
    localparam int TOTAL = N + 6;
    localparam int AW    = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [2:0]  cmd = 3'd0;
    logic [AW-1:0] addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata, checksum;
    logic        rvalid, denied, busy, locked;
    logic [7:0]  cell_pol, cell_io;
    logic [1:0]  mode_bits;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    cfg_store #(.ARRAY_WORDS(N)) i_cfg_store (
        .clk(clk), .rst(rst), .cmd(cmd), .addr(addr), .wdata(wdata),
        .rdata(rdata), .rvalid(rvalid), .denied(denied), .busy(busy),
        .locked(locked), .checksum(checksum), .cell_pol(cell_pol),
        .cell_io(cell_io), .mode_bits(mode_bits)
    );

    typedef struct packed {
        logic [2:0]  c;
        logic [3:0]  a;
        logic [15:0] wd;
        logic        rv;
        logic        dn;
        logic [15:0] rd;
        logic [15:0] ck;
        logic [7:0]  req;
    } vec_t;

    localparam int NV = 20;
    localparam vec_t VECS [NV] = '{
        '{3'd1, 4'd0,  16'h1234, 1'b0, 1'b0, 16'h0000, 16'h1234, 8'd6},  // R6
        '{3'd1, 4'd7,  16'h00FF, 1'b0, 1'b0, 16'h0000, 16'h1333, 8'd6},  // R6
        '{3'd2, 4'd0,  16'h0000, 1'b1, 1'b0, 16'h1234, 16'h1333, 8'd2},  // R2
        '{3'd2, 4'd7,  16'h0000, 1'b1, 1'b0, 16'h00FF, 16'h1333, 8'd2},  // R2
        '{3'd1, 4'd8,  16'hA55A, 1'b0, 1'b0, 16'h0000, 16'hB88D, 8'd3},  // R3
        '{3'd1, 4'd9,  16'hFFFF, 1'b0, 1'b0, 16'h0000, 16'hB890, 8'd3},  // R3
        '{3'd2, 4'd9,  16'h0000, 1'b1, 1'b0, 16'h0003, 16'hB890, 8'd3},  // R3
        '{3'd1, 4'd10, 16'h0101, 1'b0, 1'b0, 16'h0000, 16'hB991, 8'd6},  // R6
        '{3'd1, 4'd13, 16'h8000, 1'b0, 1'b0, 16'h0000, 16'h3991, 8'd6},  // R6 wrap
        '{3'd1, 4'd14, 16'h7777, 1'b0, 1'b0, 16'h0000, 16'h3991, 8'd10}, // R10
        '{3'd2, 4'd14, 16'h0000, 1'b1, 1'b0, 16'h0000, 16'h3991, 8'd10}, // R10
        '{3'd1, 4'd0,  16'h0001, 1'b0, 1'b0, 16'h0000, 16'h275E, 8'd6},  // R6 overwrite
        '{3'd4, 4'd0,  16'h0000, 1'b0, 1'b0, 16'h0000, 16'h275E, 8'd4},  // R4 lock
        '{3'd2, 4'd0,  16'h0000, 1'b1, 1'b1, 16'h0000, 16'h275E, 8'd4},  // R4
        '{3'd2, 4'd8,  16'h0000, 1'b1, 1'b1, 16'h0000, 16'h275E, 8'd4},  // R4
        '{3'd2, 4'd10, 16'h0000, 1'b1, 1'b0, 16'h0101, 16'h275E, 8'd5},  // R5
        '{3'd2, 4'd13, 16'h0000, 1'b1, 1'b0, 16'h8000, 16'h275E, 8'd5},  // R5
        '{3'd1, 4'd10, 16'hFFFF, 1'b0, 1'b0, 16'h0000, 16'h275E, 8'd9},  // R9
        '{3'd2, 4'd10, 16'h0000, 1'b1, 1'b0, 16'h0101, 16'h275E, 8'd9},  // R9
        '{3'd2, 4'd15, 16'h0000, 1'b1, 1'b0, 16'h0000, 16'h275E, 8'd10}  // R10
    };

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic step(input logic [2:0] c, input logic [3:0] a, input logic [15:0] d);
        cmd = c; addr = a; wdata = d;
        @(posedge clk);
        @(negedge clk);
        cmd = 3'd0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        int bcnt;
        string tag;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1", "busy", busy, 0);
        check("R1", "locked", locked, 0);
        check("R1", "rvalid/denied", {rvalid, denied}, 0);
        check("R1", "rdata", rdata, 0);
        check("R1", "checksum", checksum, 0);
        check("R1", "cells", {mode_bits, cell_io, cell_pol}, 0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].c, VECS[i].a, VECS[i].wd);
            tag = $sformatf("R%0d", VECS[i].req);
            check(tag, $sformatf("vec%0d rvalid", i), rvalid, VECS[i].rv);
            check(tag, $sformatf("vec%0d denied", i), denied, VECS[i].dn);
            check(tag, $sformatf("vec%0d rdata", i), rdata, VECS[i].rd);
            check(tag, $sformatf("vec%0d checksum", i), checksum, VECS[i].ck);
        end

        // R11 cell outputs under lock; R3 field placement
        check("R11", "locked", locked, 1);
        check("R11", "cell_pol", cell_pol, 8'h5A);
        check("R11", "cell_io", cell_io, 8'hA5);
        check("R3", "mode_bits", mode_bits, 2'b11);

        // R7 erase, with R8 commands injected mid-sweep
        step(3'd3, 4'd0, 16'h0);
        check("R7", "lock cleared at erase", locked, 0);
        bcnt = 0;
        while (busy && bcnt < 100) begin
            bcnt++;
            if (bcnt == 4) begin
                step(3'd1, 4'd0, 16'hBEEF);
            end else if (bcnt == 5) begin
                step(3'd2, 4'd8, 16'h0);
                check("R8", "rvalid during erase", rvalid, 0);
            end else begin
                step(3'd0, 4'd0, 16'h0);
            end
        end
        check("R7", "busy cycles", bcnt, TOTAL);
        check("R7", "checksum after erase", checksum, 0);
        check("R7", "cells after erase", {mode_bits, cell_io, cell_pol}, 0);
        step(3'd2, 4'd0, 16'h0);
        check("R8", "write during erase dropped", rdata, 0);
        check("R7", "no refusal after erase", {rvalid, denied}, 2'b10);

        // R2 normal operation resumes
        step(3'd1, 4'd3, 16'hC0DE);
        step(3'd2, 4'd3, 16'h0);
        check("R2", "read after erase", rdata, 16'hC0DE);
        check("R6", "checksum after erase", checksum, 16'hC0DE);
        step(3'd7, 4'd3, 16'h1111);
        check("R2", "reserved code idle", {rvalid, checksum}, {1'b0, 16'hC0DE});

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule